// File: doc/BRIEF.md
# Segmented Register-to-EEPROM Transfer Sequencer

This block copies scattered register ranges between a register file and a serial EEPROM in either direction. A small segment table drives it. The table holds size entries, each followed by a two-byte start address, and command opcodes mixed in among them. The table is read one byte at a time through an index port, so its storage sits outside the block. A store command walks the table and builds an EEPROM image. Every table entry goes into the image, followed at once by the register bytes of its range. An end opcode closes the image, and a checksum byte follows the end opcode.

A load command replays that image from the EEPROM. Each size entry and address in the image tells the block where to write the register bytes that follow. An update opcode in the image produces a one-cycle pulse that copies buffered registers into the active set.

The block has a write-protect bit that is clear after reset. Store is refused while that bit is clear. Two self-clearing status bits show which transfer is running, and a sticky error bit is set when the image or the table is not valid. The EEPROM is reached through a simple byte request/acknowledge handshake.

Top module: `segxfer_top`

## Requirements
- R1: After reset `busy`, `store_busy`, `load_busy`, `data_err`, `wr_enabled`, `ee_req`, `reg_we` and `io_update` are all 0.
- R2: `wr_enabled` takes `wren_val` on a cycle with `wren_wr` high. A `store_cmd` while `wr_enabled` is 0 is ignored: `busy` stays 0 and no EEPROM write is issued. EEPROM writes happen only while `store_busy` is 1.
- R3: A store writes a contiguous image from EEPROM address 0. A table byte with bit 7 clear is a size entry whose value is the byte count minus one. It is written, then the high address byte and then the low address byte. After those come the register bytes from ascending addresses starting at that address. The opcodes 0x80 and 0xFF are written as they are. After 0xFF comes one checksum byte, equal to the sum modulo 256 of all earlier image bytes.
- R4: A load reads the image from EEPROM address 0 and writes each data byte to the register address that its entry names. `reg_we` is asserted only while `load_busy` is 1.
- R5: During a load, each 0x80 opcode gives a one-cycle `io_update` pulse. A store never pulses `io_update`.
- R6: On a load, if the byte after 0xFF differs from the modulo-256 sum of all earlier image bytes, `data_err` is set when the transfer ends.
- R7: A header byte with bit 7 set that is neither 0x80 nor 0xFF ends the transfer with `data_err` set. On a store, that byte is not written.
- R8: Fetching a header byte when the count of header bytes already consumed equals `TBL_DEPTH` ends the transfer with `data_err` set.
- R9: `busy` and the matching `store_busy` or `load_busy` rise on the cycle after an accepted command and clear themselves when the transfer ends. `data_err` is cleared when a transfer starts and is set only at its end.
- R10: While `ee_req` is high and `ee_ack` is low, `ee_req`, `ee_we`, `ee_addr` and `ee_wdata` hold their values into the next cycle.
- R11: Commands that arrive while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| store_cmd | input | 1 | Pulse: start a register-to-EEPROM store |
| load_cmd | input | 1 | Pulse: start an EEPROM-to-register load |
| wren_wr | input | 1 | Strobe that writes the write-protect bit |
| wren_val | input | 1 | New value of the write-enable bit |
| wr_enabled | output | 1 | Write-enable bit; store is allowed only while it is 1 |
| busy | output | 1 | Transfer in progress |
| store_busy | output | 1 | Self-clearing store-in-progress bit |
| load_busy | output | 1 | Self-clearing load-in-progress bit |
| data_err | output | 1 | Sticky error from the last transfer |
| io_update | output | 1 | One-cycle pulse that copies buffered registers to active registers |
| tbl_idx | output | IDX_W | Segment table read index |
| tbl_byte | input | 8 | Segment table byte at `tbl_idx` (combinational) |
| reg_addr | output | 16 | Register file address |
| reg_we | output | 1 | Register file write strobe |
| reg_wdata | output | 8 | Register file write data |
| reg_rdata | input | 8 | Register file read data at `reg_addr` (combinational) |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | EEPROM request is a write |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write data |
| ee_rdata | input | 8 | EEPROM read data, valid with `ee_ack` |
| ee_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
The assertions assume a well-behaved EEPROM:

- `ee_ack` is a single-cycle pulse.
- It arrives only while a request is pending.
- Read data is valid in the acknowledge cycle.

They also assume the table and the register file answer combinationally within the same cycle, and that the table does not change during a store. The bench's EEPROM model meets these assumptions: it acknowledges one pending request after a random 0 to 2 cycle delay and then waits for the next request. The random tables stay within `TBL_DEPTH` bytes and use only ranges that fall inside the modelled register space.

// File: rtl/segxfer_pkg.sv
package segxfer_pkg;

  localparam logic [7:0] OP_IOUPD = 8'h80;
  localparam logic [7:0] OP_END   = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_GET, ST_PUT}  st_t;
  typedef enum logic [1:0] {PH_HDR, PH_DAT, PH_SUM}   ph_t;
  typedef enum logic [1:0] {K_SIZE, K_IOUPD, K_END, K_BAD} kind_t;

  // classify a header byte found where an entry or opcode is expected
  function automatic kind_t classify(input logic [7:0] b);
    if (!b[7])              return K_SIZE;
    else if (b == OP_IOUPD) return K_IOUPD;
    else if (b == OP_END)   return K_END;
    else                    return K_BAD;
  endfunction

  // running image checksum: plain modulo-256 sum
  function automatic logic [7:0] csum_next(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

endpackage

// File: rtl/segxfer_wprot.sv
module segxfer_wprot (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (wr) q <= val;
  end
endmodule

// File: rtl/segxfer_csum.sv
module segxfer_csum
  import segxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] add_byte,
  output logic [7:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= 8'h00;
    else if (clr) sum <= 8'h00;
    else if (add) sum <= csum_next(sum, add_byte);
  end
endmodule

// File: rtl/segxfer_ctrl.sv
module segxfer_ctrl
  import segxfer_pkg::*;
#(
  parameter int TBL_DEPTH = 23,
  parameter int EE_AW     = 8,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_cmd,
  input  logic             load_cmd,
  input  logic             wr_enabled,
  input  logic [7:0]       csum,
  output logic             evt_start,
  output logic             evt_done,
  output logic             csum_add,
  output logic [7:0]       csum_byte,
  output logic [IDX_W-1:0] tbl_idx,
  input  logic [7:0]       tbl_byte,
  output logic [15:0]      reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic             ee_req,
  output logic             ee_we,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       ee_wdata,
  input  logic [7:0]       ee_rdata,
  input  logic             ee_ack,
  output logic             io_update,
  output logic             busy,
  output logic             store_busy,
  output logic             load_busy,
  output logic             data_err
);
  st_t              st;
  ph_t              ph;
  logic [1:0]       fld;
  logic             mode_st;    // 1: store, 0: load
  logic [6:0]       size_q, cnt;
  logic [15:0]      raddr;
  logic [IDX_W-1:0] idx;
  logic [EE_AW-1:0] eptr;
  logic [7:0]       cur;
  logic             err_q;

  logic       got, put_done;
  logic [7:0] byte_in;
  logic       overrun, bad_op, sum_chk, sum_bad, get_fin, get_err;
  logic       start_store, start_load;

  assign start_store = (st == ST_IDLE) && store_cmd && wr_enabled;
  assign start_load  = (st == ST_IDLE) && load_cmd && !start_store;
  assign evt_start   = start_store || start_load;

  // per-state datapath steering
  always_comb begin
    ee_req    = 1'b0;
    ee_we     = 1'b0;
    reg_we    = 1'b0;
    io_update = 1'b0;
    got       = 1'b0;
    put_done  = 1'b0;
    byte_in   = 8'h00;
    case (st)
      ST_GET: begin
        if (!mode_st) begin
          ee_req  = 1'b1;
          got     = ee_ack;
          byte_in = ee_rdata;
        end else begin
          got = 1'b1;
          case (ph)
            PH_HDR:  byte_in = tbl_byte;
            PH_DAT:  byte_in = reg_rdata;
            default: byte_in = csum;
          endcase
        end
      end
      ST_PUT: begin
        if (mode_st) begin
          ee_req   = 1'b1;
          ee_we    = 1'b1;
          put_done = ee_ack;
        end else begin
          put_done  = 1'b1;
          reg_we    = (ph == PH_DAT);
          io_update = (ph == PH_HDR) && (fld == 2'd0) && (cur == OP_IOUPD);
        end
      end
      default: ;
    endcase
  end

  assign overrun  = got && (ph == PH_HDR) && (idx == IDX_W'(TBL_DEPTH));
  assign bad_op   = got && (ph == PH_HDR) && (fld == 2'd0) && (classify(byte_in) == K_BAD);
  assign sum_chk  = got && (ph == PH_SUM) && !mode_st;
  assign sum_bad  = sum_chk && (byte_in != csum);
  assign get_fin  = overrun || bad_op || sum_chk;
  assign get_err  = overrun || bad_op || sum_bad;
  assign evt_done = get_fin || (put_done && (ph == PH_SUM));

  assign csum_add  = mode_st ? (put_done && (ph != PH_SUM))
                             : (got && (ph != PH_SUM));
  assign csum_byte = mode_st ? cur : byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_HDR;
      fld     <= 2'd0;
      mode_st <= 1'b0;
      size_q  <= '0;
      cnt     <= '0;
      raddr   <= '0;
      idx     <= '0;
      eptr    <= '0;
      cur     <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (evt_start) begin
          mode_st <= start_store;
          st      <= ST_GET;
          ph      <= PH_HDR;
          fld     <= 2'd0;
          idx     <= '0;
          eptr    <= '0;
          err_q   <= 1'b0;
        end
        ST_GET: if (got) begin
          if (get_fin) begin
            st    <= ST_IDLE;
            err_q <= get_err;
          end else begin
            cur <= byte_in;
            st  <= ST_PUT;
            if (ph == PH_HDR) idx  <= idx + 1'b1;
            if (!mode_st)     eptr <= eptr + 1'b1;
          end
        end
        ST_PUT: if (put_done) begin
          if (mode_st) eptr <= eptr + 1'b1;
          st <= ST_GET;
          case (ph)
            PH_HDR: begin
              case (fld)
                2'd0: begin
                  case (classify(cur))
                    K_SIZE: begin size_q <= cur[6:0]; fld <= 2'd1; end
                    K_END:  ph <= PH_SUM;
                    default: ;
                  endcase
                end
                2'd1: begin raddr[15:8] <= cur; fld <= 2'd2; end
                default: begin
                  raddr[7:0] <= cur;
                  fld        <= 2'd0;
                  cnt        <= size_q;
                  ph         <= PH_DAT;
                end
              endcase
            end
            PH_DAT: begin
              raddr <= raddr + 16'd1;
              if (cnt == '0) ph <= PH_HDR;
              else           cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;   // checksum byte stored
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tbl_idx    = idx;
  assign reg_addr   = raddr;
  assign reg_wdata  = cur;
  assign ee_addr    = eptr;
  assign ee_wdata   = cur;
  assign busy       = (st != ST_IDLE);
  assign store_busy = busy && mode_st;
  assign load_busy  = busy && !mode_st;
  assign data_err   = err_q;

endmodule

// File: rtl/segxfer_top.sv
module segxfer_top
  import segxfer_pkg::*;
#(
  parameter int TBL_DEPTH = 23,
  parameter int EE_AW     = 8,
  localparam int IDX_W    = $clog2(TBL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_cmd,
  input  logic             load_cmd,
  input  logic             wren_wr,
  input  logic             wren_val,
  output logic             wr_enabled,
  output logic             busy,
  output logic             store_busy,
  output logic             load_busy,
  output logic             data_err,
  output logic             io_update,
  output logic [IDX_W-1:0] tbl_idx,
  input  logic [7:0]       tbl_byte,
  output logic [15:0]      reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic             ee_req,
  output logic             ee_we,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       ee_wdata,
  input  logic [7:0]       ee_rdata,
  input  logic             ee_ack
);
  logic       evt_start, evt_done;
  logic       csum_add;
  logic [7:0] csum_byte, csum;

  segxfer_wprot u_wprot (
    .clk(clk), .rst_n(rst_n), .wr(wren_wr), .val(wren_val), .q(wr_enabled)
  );

  segxfer_csum u_csum (
    .clk(clk), .rst_n(rst_n), .clr(evt_start), .add(csum_add),
    .add_byte(csum_byte), .sum(csum)
  );

  segxfer_ctrl #(.TBL_DEPTH(TBL_DEPTH), .EE_AW(EE_AW), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .store_cmd(store_cmd), .load_cmd(load_cmd), .wr_enabled(wr_enabled),
    .csum(csum), .evt_start(evt_start), .evt_done(evt_done),
    .csum_add(csum_add), .csum_byte(csum_byte),
    .tbl_idx(tbl_idx), .tbl_byte(tbl_byte),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_rdata(ee_rdata), .ee_ack(ee_ack),
    .io_update(io_update), .busy(busy), .store_busy(store_busy),
    .load_busy(load_busy), .data_err(data_err)
  );

endmodule

// File: rtl/segxfer_chk.sv
module segxfer_chk #(
  parameter int EE_AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             store_cmd,
  input logic             wr_enabled,
  input logic             busy,
  input logic             store_busy,
  input logic             load_busy,
  input logic             data_err,
  input logic             io_update,
  input logic             reg_we,
  input logic             ee_req,
  input logic             ee_we,
  input logic [EE_AW-1:0] ee_addr,
  input logic [7:0]       ee_wdata,
  input logic             ee_ack,
  input logic             evt_done
);
  assert_regwe_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> load_busy);

  assert_eewr_in_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && ee_we) |-> store_busy);

  assert_refused_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd && !wr_enabled && !busy) |=> !store_busy);

  assert_io_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_update |-> load_busy);

  assert_io_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_update |=> !io_update);

  assert_err_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_err) |-> !busy);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !busy);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_we) && $stable(ee_addr) && $stable(ee_wdata)));
endmodule

bind segxfer_top segxfer_chk #(.EE_AW(EE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .store_cmd(store_cmd), .wr_enabled(wr_enabled),
  .busy(busy), .store_busy(store_busy), .load_busy(load_busy),
  .data_err(data_err), .io_update(io_update), .reg_we(reg_we),
  .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
  .ee_ack(ee_ack), .evt_done(evt_done)
);

// File: tb/segxfer_top_tb.sv
module segxfer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDEP = 23;
  localparam int EAW  = 8;
  localparam int IW   = $clog2(TDEP + 1);
  localparam int NREG = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic store_cmd = 1'b0, load_cmd = 1'b0, wren_wr = 1'b0, wren_val = 1'b0;
  logic wr_enabled, busy, store_busy, load_busy, data_err, io_update;
  logic [IW-1:0] tbl_idx;
  logic [7:0] tbl_byte;
  logic [15:0] reg_addr;
  logic reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic ee_req, ee_we;
  logic [EAW-1:0] ee_addr;
  logic [7:0] ee_wdata;
  logic [7:0] ee_rdata = 8'h00;
  logic ee_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segxfer_top #(.TBL_DEPTH(TDEP), .EE_AW(EAW)) u_dut (
    .clk(clk), .rst_n(rst_n), .store_cmd(store_cmd), .load_cmd(load_cmd),
    .wren_wr(wren_wr), .wren_val(wren_val), .wr_enabled(wr_enabled),
    .busy(busy), .store_busy(store_busy), .load_busy(load_busy),
    .data_err(data_err), .io_update(io_update),
    .tbl_idx(tbl_idx), .tbl_byte(tbl_byte),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_rdata(ee_rdata), .ee_ack(ee_ack)
  );

  // table, register file and EEPROM models
  logic [7:0] tbl [0:TDEP-1];
  assign tbl_byte = (int'(tbl_idx) < TDEP) ? tbl[tbl_idx] : 8'h00;

  logic [7:0] regs [0:NREG-1];
  logic [7:0] fill_src [0:NREG-1];
  logic fill_req = 1'b0;
  assign reg_rdata = regs[reg_addr[9:0]];
  always @(posedge clk) begin
    if (fill_req) for (int k = 0; k < NREG; k++) regs[k] <= fill_src[k];
    else if (reg_we) regs[reg_addr[9:0]] <= reg_wdata;
  end

  logic [7:0] ee_mem [0:255];
  logic poke_en = 1'b0;
  logic [7:0] poke_addr = 8'h00, poke_val = 8'h00;
  int lat = 0, wr_cnt = 0, io_cnt = 0;
  bit saw_load_busy = 1'b0;
  always @(posedge clk) begin
    ee_ack <= 1'b0;
    if (poke_en) ee_mem[poke_addr] <= poke_val;
    if (ee_req && !ee_ack) begin
      if (lat == 0) begin
        ee_ack <= 1'b1;
        if (ee_we) begin ee_mem[ee_addr] <= ee_wdata; wr_cnt <= wr_cnt + 1; end
        else ee_rdata <= ee_mem[ee_addr];
        lat <= int'($urandom % 3);
      end else lat <= lat - 1;
    end
    if (io_update) io_cnt <= io_cnt + 1;
    if (load_busy) saw_load_busy <= 1'b1;
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  // expected image built from the table and current registers
  logic [7:0] exp_img [0:255];
  int exp_len, exp_io;
  bit exp_err;
  bit cov [0:NREG-1];
  logic [7:0] saved [0:NREG-1];

  function automatic void put_img(input logic [7:0] v, inout logic [7:0] s);
    exp_img[exp_len] = v;
    exp_len++;
    s = s + v;
  endfunction

  function automatic void model_image();
    int i, fld, sz;
    logic [7:0] b, s;
    logic [15:0] a;
    exp_len = 0; exp_io = 0; exp_err = 0; s = 8'h00; i = 0; fld = 0; sz = 0; a = '0;
    for (int k = 0; k < NREG; k++) cov[k] = 1'b0;
    while (1) begin
      if (i >= TDEP) begin exp_err = 1; break; end
      b = tbl[i]; i++;
      if (fld == 0) begin
        if (b == 8'hFF) begin put_img(b, s); put_img(s, s); break; end
        else if (b == 8'h80) begin put_img(b, s); exp_io++; end
        else if (b[7]) begin exp_err = 1; break; end
        else begin put_img(b, s); sz = int'(b); fld = 1; end
      end else if (fld == 1) begin
        put_img(b, s); a[15:8] = b; fld = 2;
      end else begin
        put_img(b, s); a[7:0] = b; fld = 0;
        for (int k = 0; k <= sz; k++) begin
          put_img(regs[(int'(a) + k) % NREG], s);
          cov[(int'(a) + k) % NREG] = 1'b1;
        end
      end
    end
  endfunction

  task automatic fill_regs(input bit zero);
    for (int k = 0; k < NREG; k++) fill_src[k] = zero ? 8'h00 : 8'($urandom);
    @(negedge clk); fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
  endtask

  task automatic poke(input int adr, input logic [7:0] v);
    @(negedge clk); poke_en = 1'b1; poke_addr = 8'(adr); poke_val = v;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic run_op(input bit do_store, input string tag);
    int guard;
    @(negedge clk);
    if (do_store) store_cmd = 1'b1; else load_cmd = 1'b1;
    @(negedge clk);
    store_cmd = 1'b0; load_cmd = 1'b0;
    chk(busy && (do_store ? store_busy : load_busy), {tag, " R9 busy after command"},
        int'(busy), 1);
    guard = 0;
    while (busy && guard < 30000) begin @(negedge clk); guard++; end
    chk(!busy && !store_busy && !load_busy, {tag, " R9 self-clear at end"}, int'(busy), 0);
  endtask

  function automatic int img_mismatch();
    int bad = 0;
    for (int j = 0; j < exp_len; j++) if (ee_mem[j] !== exp_img[j]) bad++;
    return bad;
  endfunction

  function automatic int reg_mismatch();
    int bad = 0;
    for (int k = 0; k < NREG; k++)
      if (regs[k] !== (cov[k] ? saved[k] : fill_src[k])) bad++;
    return bad;
  endfunction

  task automatic set_default_table();
    logic [7:0] d [0:TDEP-1];
    d = '{8'h00,8'h00,8'h00, 8'h02,8'h00,8'h04, 8'h0E,8'h00,8'h10, 8'h0E,8'h00,8'hF0,
          8'h2B,8'h01,8'h90, 8'h01,8'h01,8'hE0, 8'h03,8'h02,8'h30, 8'h80, 8'hFF};
    for (int k = 0; k < TDEP; k++) tbl[k] = d[k];
  endtask

  task automatic gen_table();
    int pos = 0;
    int nseg = 1 + int'($urandom % 6);
    for (int k = 0; k < TDEP; k++) tbl[k] = 8'h00;
    for (int s = 0; s < nseg; s++) begin
      logic [15:0] a;
      if (($urandom % 4) == 0 && pos + 1 <= 21) begin tbl[pos] = 8'h80; pos++; end
      if (pos + 3 > 21) break;
      a = 16'($urandom % 1000);
      tbl[pos] = 8'($urandom % 16); tbl[pos+1] = a[15:8]; tbl[pos+2] = a[7:0];
      pos += 3;
    end
    tbl[pos] = 8'hFF;
  endtask

  task automatic store_and_load(input string tag);
    int w0, io0;
    model_image();
    for (int k = 0; k < NREG; k++) saved[k] = regs[k];
    w0 = wr_cnt; io0 = io_cnt;
    run_op(1'b1, tag);
    chk(img_mismatch() == 0, {tag, " R3 image bytes"}, img_mismatch(), 0);
    chk(wr_cnt - w0 == exp_len, {tag, " R3 write count"}, wr_cnt - w0, exp_len);
    chk(io_cnt == io0, {tag, " R5 no io_update on store"}, io_cnt - io0, 0);
    chk(data_err == 1'b0, {tag, " R6 store error flag"}, int'(data_err), 0);
    fill_regs(1'b0);
    io0 = io_cnt;
    run_op(1'b0, tag);
    chk(reg_mismatch() == 0, {tag, " R4 registers after load"}, reg_mismatch(), 0);
    chk(io_cnt - io0 == exp_io, {tag, " R5 io_update pulses"}, io_cnt - io0, exp_io);
    chk(data_err == 1'b0, {tag, " R6 load checksum ok"}, int'(data_err), 0);
  endtask

  initial begin
    int w0, io0;
    void'($urandom(32'h5EED_0117));
    for (int k = 0; k < 256; k++) ee_mem[k] = 8'h00;
    for (int k = 0; k < NREG; k++) regs[k] = 8'h00;
    set_default_table();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !store_busy && !load_busy, "R1 busy bits in reset", int'(busy), 0);
    chk(!data_err && !wr_enabled, "R1 error and write-enable in reset", int'(data_err), 0);
    chk(!ee_req && !reg_we && !io_update, "R1 no requests in reset", int'(ee_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_enabled, "R1 idle after reset release", int'(busy), 0);

    fill_regs(1'b0);

    // R2 store refused while protect bit clear
    w0 = wr_cnt;
    @(negedge clk); store_cmd = 1'b1;
    @(negedge clk); store_cmd = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy, "R2 refused store stays idle", int'(busy), 0);
    chk(wr_cnt == w0, "R2 refused store writes nothing", wr_cnt - w0, 0);

    @(negedge clk); wren_wr = 1'b1; wren_val = 1'b1;
    @(negedge clk); wren_wr = 1'b0;
    chk(wr_enabled == 1'b1, "R2 write enable set", int'(wr_enabled), 1);

    // R11 load command while store busy is ignored
    model_image();
    w0 = wr_cnt;
    @(negedge clk); store_cmd = 1'b1;
    @(negedge clk); store_cmd = 1'b0; load_cmd = 1'b1;
    @(negedge clk); load_cmd = 1'b0;
    while (busy) @(negedge clk);
    chk(!saw_load_busy, "R11 load during store ignored", int'(saw_load_busy), 0);
    chk(img_mismatch() == 0, "R3 default table image", img_mismatch(), 0);
    chk(wr_cnt - w0 == exp_len, "R3 default table write count", wr_cnt - w0, exp_len);

    // default table full round trip
    fill_regs(1'b0);
    store_and_load("default");

    // R6 corrupted data byte -> checksum mismatch
    poke(3, ee_mem[3] ^ 8'h01);
    run_op(1'b0, "corrupt");
    chk(data_err == 1'b1, "R6 checksum mismatch flagged", int'(data_err), 1);

    // R7 unknown opcode in EEPROM image on load: no register written
    poke(0, 8'hC3);
    fill_regs(1'b0);
    for (int k = 0; k < NREG; k++) cov[k] = 1'b0;
    io0 = io_cnt;
    run_op(1'b0, "badop-load");
    chk(data_err == 1'b1, "R7 unknown opcode on load", int'(data_err), 1);
    chk(reg_mismatch() == 0, "R7 registers untouched", reg_mismatch(), 0);
    chk(io_cnt == io0, "R7 no io_update", io_cnt - io0, 0);

    // R7 unknown opcode in table on store
    for (int k = 0; k < TDEP; k++) tbl[k] = 8'hFF;
    tbl[0] = 8'h01; tbl[1] = 8'h00; tbl[2] = 8'h20; tbl[3] = 8'h9C;
    model_image();
    w0 = wr_cnt;
    run_op(1'b1, "badop-store");
    chk(data_err == 1'b1, "R7 unknown opcode on store", int'(data_err), 1);
    chk(wr_cnt - w0 == exp_len, "R7 writes before bad opcode", wr_cnt - w0, exp_len);
    chk(exp_len == 5, "R7 model write count", exp_len, 5);

    // R8 table without end marker
    for (int s = 0; s < 7; s++) begin
      tbl[3*s] = 8'h00; tbl[3*s+1] = 8'h01; tbl[3*s+2] = 8'(16*s);
    end
    tbl[21] = 8'h80; tbl[22] = 8'h80;
    model_image();
    w0 = wr_cnt;
    run_op(1'b1, "overrun");
    chk(data_err == 1'b1, "R8 table overrun flagged", int'(data_err), 1);
    chk(wr_cnt - w0 == 30, "R8 writes before overrun", wr_cnt - w0, 30);

    // R9 error cleared by a new transfer
    for (int it = 0; it < 20; it++) begin
      gen_table();
      fill_regs(1'b0);
      store_and_load("random");
    end

    finish_run();
  end
endmodule